// File: doc/BRIEF.md
# I2C Bus Lockup Recovery Sequencer

A slave device can be left in the middle of a transfer when the chip resets. If that slave is driving a data bit at the moment of reset, it keeps SDA low, and the bus stays stuck: any controller that looks at it sees a bus that never goes idle. This block runs once after every reset, before the normal two-wire controller is allowed onto the pins, and frees the bus.

After a short settling phase it clocks SCL slowly, one pulse at a time, up to a fixed maximum number of pulses. At the end of every high phase it looks at the synchronized SDA line. The first time SDA reads high, the remaining pulses are skipped. The block then issues a START followed by a STOP, which returns every slave to idle. If SDA is still low after the last pulse, the block raises a fail flag and releases both lines. In both cases it raises done and passes the pins to the normal controller.

Both pin outputs are open-drain style: 0 pulls the line low and 1 releases it. Both pin inputs pass through two-flop synchronizers. A slave that stretches the clock is honoured: a released SCL that still reads low is waited for before the high phase is timed.

Top module: `i2c_unlock_seq`

## Requirements
- R1: While rst_n is low, scl_o and sda_o are 1 (released), and done_o, fail_o and grant_o are 0.
- R2: Every SCL low phase that the sequencer drives lasts exactly PHASE_CLKS clocks, plus any cycles that a slave holds SCL low after release. Every high phase lasts at least PHASE_CLKS clocks.
- R3: The sequencer generates at least one and at most MAX_PULSES falling SCL edges. It stops after the first pulse whose high phase ends with SDA read as 1.
- R4: Once SDA has been read as 1, the sequencer issues a START (SDA goes 1 to 0 while SCL is 1) and then a STOP (SDA goes 0 to 1 while SCL is 1), with no SCL edge between them.
- R5: If SDA still reads 0 at the end of pulse MAX_PULSES, fail_o and done_o are set together, both sequencer outputs are released, and no START is issued.
- R6: While the sequencer releases SCL but SCL reads low, it waits. It times the high phase only after SCL is seen high, and stretching does not change the pulse count.
- R7: Before done_o, scl_o and sda_o follow the sequencer, and ctl_scl_i and ctl_sda_i have no effect. After done_o, grant_o is 1 and scl_o and sda_o equal ctl_scl_i and ctl_sda_i.
- R8: Once set, done_o stays set until the next reset. Every reset restarts the full sequence.
- R9: The sequencer never pulls SDA low while SCL is low. It drives SDA only for the START, with SCL released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line as seen at the pin |
| sda_i | input | 1 | SDA line as seen at the pin |
| ctl_scl_i | input | 1 | SCL output of the normal controller (0 = pull low) |
| ctl_sda_i | input | 1 | SDA output of the normal controller (0 = pull low) |
| scl_o | output | 1 | SCL pin output, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA pin output, 0 pulls low, 1 releases |
| done_o | output | 1 | Recovery finished |
| fail_o | output | 1 | SDA never released within MAX_PULSES pulses |
| grant_o | output | 1 | 1 when the normal controller owns the pins |

## Verification
The bench builds the block with PHASE_CLKS=4 and MAX_PULSES=9. The short phase keeps each run to about a hundred cycles, so every run can be covered. It sweeps the point at which a modelled slave lets go of SDA, from already released through each pulse number up to one pulse past the limit, so both the early-stop and the fail outcome are exercised. Each of these points is run with no clock stretching and with a two-cycle stretch on every pulse, which exposes the exact low-phase length and the wait for SCL.

// File: rtl/i2c_unlock_pkg.sv
package i2c_unlock_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_LOW,
        ST_WAIT,
        ST_HIGH,
        ST_START,
        ST_STOP,
        ST_DONE
    } seq_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/i2c_unlock_sync.sv
module i2c_unlock_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], d_i[b]};
        end

        // idle bus reads high, so reset every stage to 1
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2c_unlock_timer.sv
module i2c_unlock_timer #(
    parameter int unsigned PHASE_CLKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);

    localparam int unsigned CNT_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CLKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == CNT_LAST);
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_o) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2c_unlock_fsm.sv
module i2c_unlock_fsm
    import i2c_unlock_pkg::*;
#(
    parameter int unsigned MAX_PULSES = 9,
    parameter int unsigned PULSE_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_s_i,
    input  logic               sda_s_i,
    input  logic               tick_i,
    output logic               clr_o,
    output logic               seq_scl_o,
    output logic               seq_sda_o,
    output logic               done_o,
    output logic               fail_o,
    output logic [PULSE_W-1:0] pulses_o
);

    localparam logic [PULSE_W-1:0] PULSE_LAST = PULSE_W'(MAX_PULSES - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [PULSE_W-1:0] pulses;
        logic               done;
        logic               fail;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_BOOT: begin
                if (tick_i) fsm_d.st = ST_LOW;
            end
            ST_LOW: begin
                if (tick_i) fsm_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                // a stretching slave keeps us here
                if (scl_s_i) fsm_d.st = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick_i) begin
                    fsm_d.pulses = fsm_q.pulses + PULSE_W'(1);
                    if (sda_s_i) begin
                        fsm_d.st = ST_START;
                    end else if (fsm_q.pulses == PULSE_LAST) begin
                        fsm_d.st   = ST_DONE;
                        fsm_d.done = 1'b1;
                        fsm_d.fail = 1'b1;
                    end else begin
                        fsm_d.st = ST_LOW;
                    end
                end
            end
            ST_START: begin
                if (tick_i) fsm_d.st = ST_STOP;
            end
            ST_STOP: begin
                if (tick_i) begin
                    fsm_d.st   = ST_DONE;
                    fsm_d.done = 1'b1;
                end
            end
            default: begin
                fsm_d = fsm_q;
            end
        endcase
        // restart phase timing on every state change and while waiting for SCL
        clr_o = (fsm_d.st != fsm_q.st) || (fsm_q.st == ST_WAIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st     <= ST_BOOT;
            fsm_q.pulses <= '0;
            fsm_q.done   <= 1'b0;
            fsm_q.fail   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign seq_scl_o = (fsm_q.st != ST_LOW);
    assign seq_sda_o = (fsm_q.st != ST_START);
    assign done_o    = fsm_q.done;
    assign fail_o    = fsm_q.fail;
    assign pulses_o  = fsm_q.pulses;

endmodule

// File: rtl/i2c_unlock_seq.sv
module i2c_unlock_seq
    import i2c_unlock_pkg::*;
#(
    parameter int unsigned PHASE_CLKS = 250,
    parameter int unsigned MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic ctl_scl_i,
    input  logic ctl_sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic done_o,
    output logic fail_o,
    output logic grant_o
);

    // PHASE_CLKS must exceed SYNC_STAGES so a driven-low SCL is seen before the wait
    localparam int unsigned PULSE_W = $clog2(MAX_PULSES + 1);

    logic [1:0]         pins_s;
    logic               scl_s, sda_s;
    logic               tick, clr;
    logic               seq_scl, seq_sda;
    logic               done, fail;
    logic [PULSE_W-1:0] pulses;

    i2c_unlock_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sda_i, scl_i}),
        .q_o   (pins_s)
    );

    assign scl_s = pins_s[0];
    assign sda_s = pins_s[1];

    i2c_unlock_timer #(
        .PHASE_CLKS (PHASE_CLKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .tick_o (tick)
    );

    i2c_unlock_fsm #(
        .MAX_PULSES (MAX_PULSES),
        .PULSE_W    (PULSE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s_i   (scl_s),
        .sda_s_i   (sda_s),
        .tick_i    (tick),
        .clr_o     (clr),
        .seq_scl_o (seq_scl),
        .seq_sda_o (seq_sda),
        .done_o    (done),
        .fail_o    (fail),
        .pulses_o  (pulses)
    );

    // pin ownership moves to the controller only once recovery is over
    always_comb begin
        grant_o = done;
        if (done) begin
            scl_o = ctl_scl_i;
            sda_o = ctl_sda_i;
        end else begin
            scl_o = seq_scl;
            sda_o = seq_sda;
        end
    end

    assign done_o = done;
    assign fail_o = fail;

endmodule

// File: rtl/i2c_unlock_chk.sv
module i2c_unlock_chk #(
    parameter int unsigned MAX_PULSES = 9,
    parameter int unsigned PULSE_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               fail,
    input logic               seq_scl,
    input logic               seq_sda,
    input logic               sda_s,
    input logic [PULSE_W-1:0] pulses
);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_fail_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    p_fail_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (seq_scl && seq_sda));

    p_fail_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (pulses == PULSE_W'(MAX_PULSES)));

    p_pulse_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= PULSE_W'(MAX_PULSES));

    p_sda_only_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_sda |-> seq_scl);

    p_start_after_sda_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_sda) |-> $past(sda_s));

endmodule

bind i2c_unlock_seq i2c_unlock_chk #(
    .MAX_PULSES (MAX_PULSES),
    .PULSE_W    (PULSE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .fail    (fail),
    .seq_scl (seq_scl),
    .seq_sda (seq_sda),
    .sda_s   (sda_s),
    .pulses  (pulses)
);

// File: tb/i2c_unlock_seq_test.sv
module i2c_unlock_seq_test;

    localparam int PH   = 4;
    localparam int MAXP = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_scl = 1'b0;
    logic ctl_sda = 1'b0;
    logic scl_o, sda_o, done_o, fail_o, grant_o;
    logic scl_line, sda_line;

    int k_cfg = 0;     // slave releases SDA once this many SCL rises are seen
    int s_cfg = 0;     // slave stretch cycles per pulse
    int rises;
    int st_cnt;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    // monitor state
    int falls, lows_bad, highs_bad, starts, stops, sda_bad, edges_after, run;
    logic ps = 1'b1;
    logic pd = 1'b1;

    always #5 clk = ~clk;

    assign scl_line = scl_o & (st_cnt >= s_cfg);
    assign sda_line = sda_o & (rises >= k_cfg);

    i2c_unlock_seq #(
        .PHASE_CLKS (PH),
        .MAX_PULSES (MAXP)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .ctl_scl_i (ctl_scl),
        .ctl_sda_i (ctl_sda),
        .scl_o     (scl_o),
        .sda_o     (sda_o),
        .done_o    (done_o),
        .fail_o    (fail_o),
        .grant_o   (grant_o)
    );

    // slave: counts SCL rises on the line
    always @(posedge scl_line or negedge rst_n) begin
        if (!rst_n) rises <= 0;
        else        rises <= rises + 1;
    end

    // slave: stretches SCL for s_cfg cycles after each release
    always @(posedge clk) begin
        if (!rst_n)     st_cnt <= 100;
        else if (!scl_o) st_cnt <= 0;
        else if (st_cnt < s_cfg) st_cnt <= st_cnt + 1;
    end

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            falls = 0; lows_bad = 0; highs_bad = 0; starts = 0;
            stops = 0; sda_bad = 0; edges_after = 0; run = 0;
        end else if (!done_o) begin
            if (scl_line != ps) begin
                if (!ps && run != PH + s_cfg) lows_bad++;
                if (ps && falls > 0 && starts == 0 && run < PH) highs_bad++;
                if (starts > 0) edges_after++;
                if (ps) falls++;
                run = 1;
            end else begin
                run++;
            end
            if (scl_line && ps && pd && !sda_line) starts++;
            if (scl_line && ps && !pd && sda_line && starts > 0) stops++;
            if (!scl_line && !ps && pd && !sda_line) sda_bad++;
        end
        ps = scl_line;
        pd = sda_line;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s k=%0d s=%0d actual=%0d expected=%0d", what, k_cfg, s_cfg, act, exp);
        end
    endtask

    task automatic run_case(input int k, input int s);
        int exp_p;
        bit exp_fail;
        int waited;
        @(negedge clk);
        rst_n = 1'b0;
        ctl_scl = 1'b0;
        ctl_sda = 1'b0;
        k_cfg = k;
        s_cfg = s;
        repeat (3) @(negedge clk);
        chk(scl_o && sda_o, "R1 pins released in reset", {scl_o, sda_o}, 3);
        chk(!done_o && !fail_o && !grant_o, "R1 flags clear in reset",
            {done_o, fail_o, grant_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(scl_o && sda_o && !grant_o, "R7 controller ignored before done",
            {grant_o, scl_o, sda_o}, 3);
        waited = 0;
        while (!done_o && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_o, "R8 done reached", done_o, 1);
        exp_fail = (k > MAXP);
        exp_p = (k == 0) ? 1 : ((k <= MAXP) ? k : MAXP);
        chk(falls == exp_p, "R3 pulse count", falls, exp_p);
        chk(fail_o == exp_fail, "R5 fail flag", fail_o, exp_fail);
        chk(lows_bad == 0, "R2 low phase length", lows_bad, 0);
        chk(highs_bad == 0, "R6 high phase timed after SCL seen high", highs_bad, 0);
        chk(sda_bad == 0, "R9 SDA never falls with SCL low", sda_bad, 0);
        if (exp_fail) begin
            chk(starts == 0, "R5 no START on failure", starts, 0);
        end else begin
            chk(starts == 1, "R4 START issued", starts, 1);
            chk(stops == 1, "R4 STOP after START", stops, 1);
            chk(edges_after == 0, "R4 no SCL edge between START and STOP", edges_after, 0);
        end
        repeat (5) @(negedge clk);
        chk(done_o && grant_o, "R8 done stays set, R7 grant", {done_o, grant_o}, 3);
        for (int c = 0; c < 4; c++) begin
            ctl_scl = c[0];
            ctl_sda = c[1];
            #1;
            chk(scl_o == c[0] && sda_o == c[1], "R7 pins follow controller",
                {sda_o, scl_o}, c);
        end
    endtask

    initial begin
        for (int s = 0; s <= 2; s += 2) begin
            for (int k = 0; k <= MAXP + 1; k++) begin
                run_case(k, s);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule